// File: doc/BRIEF.md
# Guarded Mealy Controller with Concurrent Fault Checkers

This block is a small Mealy controller with five states, a 2-bit control input and a 3-bit command output. Concurrent checkers watch every stage of the machine: the incoming input vector, the present-state code as it is fed back into the logic, the next-state code before it is loaded, the output vector, and the (present, next) state pair.

When any checker fires, the command output is forced to the all-zero safe vector in the same cycle and the state register stops loading. A fault flag and a per-check cause vector are raised, and both stay set until a synchronous reset. Nothing else clears them. A test hook can XOR a mask into the fed-back state, the next-state code or the output vector, so that each checker can be made to fire on purpose.

The input is sampled on every clock edge and the output is combinational from state and input. The block therefore has plain control pins and no valid/ready flow and no back-pressure. The state encoding is set at elaboration, one-hot or binary, and the port behaviour is the same for both.

Top module: `sfg_guarded_fsm`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine enters state S0 and clears the fault flag and all cause bits. In S0 with input 00, `y_o` is 000.
- R2: For defined inputs, the machine follows this table, written as state: input -> next/output. S0: 00->S0/000, 01->S1/001. S1: 00->S1/010, 01->S2/011, 10->S0/100. S2: 00->S2/000, 10->S3/101. S3: 00->S3/110, 01->S4/001. S4: 00->S4/010, 01->S0/100, 10->S1/101.
- R3: An input of 11 is illegal in every state, and any input missing from the R2 row of the present state is illegal in that state. Either case sets cause bit 0.
- R4: Cause bit 1 is set for any of these output conditions: the output is 111; the output is not one that the present state's row can produce; or the output differs from the one listed for the (present, next) pair being taken.
- R5: Cause bit 2 is set when the fed-back present-state code is not a valid code. While the present code is invalid, the per-state input and output checks and the transition check are not evaluated.
- R6: Cause bit 3 is set when the next-state code is not a valid code. While the fault flag is high, the state register is not loaded.
- R7: Cause bit 4 is set when both codes are valid but the (present, next) pair is not an edge of the R2 table.
- R8: In the cycle a fault is detected, and in every later cycle, `y_o` is 000.
- R9: `fault_o` and every set bit of `cause_o` stay high until reset, even after the faulty condition goes away.
- R10: Parameter `ENC` selects the encoding. In one-hot, state Sk is the code with only bit k set, and a code is valid only if exactly one bit is set. In binary, Sk is the number k, and only 0 to 4 are valid. Both encodings give identical port behaviour.
- R11: `inj_sel_i` selects the injection point: 00 none, 01 the fed-back present state, 10 the next-state code, 11 the output. The low bits of `inj_mask_i` are XORed into the selected value.
- R12: Faults in different stages are flagged in the same cycle, and their cause bits are combined in `cause_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x_i | input | 2 | Control input vector |
| inj_sel_i | input | 2 | Test hook: injection point |
| inj_mask_i | input | 5 | Test hook: XOR mask |
| y_o | output | 3 | Command output, zero while faulted |
| fault_o | output | 1 | Sticky fault flag |
| cause_o | output | 5 | Sticky cause bits: 0 input, 1 output, 2 present, 3 next, 4 transition |

## Verification
The transition fault is the hardest case to reach, because both codes must be valid while the pair is not an edge of the graph. A one-hot code with a single flipped bit is never valid, so a single flip cannot produce it. The bench instead drives a two-bit mask into the next-state code, which clears the true bit and sets the bit of an unreachable state. On the binary instance, a one-bit flip lands on a valid code. Every state and input pair is swept from reset on both encodings, and each injection point is exercised on each side while the other instance serves as a clean reference.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic {ENC_ONEHOT = 1'b0, ENC_BINARY = 1'b1} enc_e;
  typedef enum logic [1:0] {INJ_NONE = 2'd0, INJ_STATE = 2'd1, INJ_NEXT = 2'd2, INJ_OUT = 2'd3} inj_e;

  localparam int NUM_ST  = 5;
  localparam int IN_W    = 2;
  localparam int OUT_W   = 3;
  localparam int IDX_W   = $clog2(NUM_ST);
  localparam int INJ_W   = NUM_ST;
  localparam int CAUSE_W = 5;

  localparam int C_IN  = 0;
  localparam int C_OUT = 1;
  localparam int C_PS  = 2;
  localparam int C_NS  = 3;
  localparam int C_TR  = 4;

  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [IN_W-1:0]    in_t;
  typedef logic [OUT_W-1:0]   out_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    logic ok;
    out_t y;
  } edge_t;

  function automatic logic in_global_ok(in_t x);
    return x != '1;
  endfunction

  function automatic logic in_state_ok(idx_t s, in_t x);
    case (int'(s))
      0: return int'(x) inside {0, 1};
      1: return int'(x) inside {0, 1, 2};
      2: return int'(x) inside {0, 2};
      3: return int'(x) inside {0, 1};
      4: return int'(x) inside {0, 1, 2};
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic out_global_ok(out_t y);
    return y != '1;
  endfunction

  function automatic logic out_state_ok(idx_t s, out_t y);
    case (int'(s))
      0: return int'(y) inside {0, 1};
      1: return int'(y) inside {2, 3, 4};
      2: return int'(y) inside {0, 5};
      3: return int'(y) inside {1, 6};
      4: return int'(y) inside {2, 4, 5};
      default: return 1'b0;
    endcase
  endfunction

  // Graph edges keyed by (present*8 + next); each edge carries its own output.
  function automatic edge_t edge_lookup(idx_t p, idx_t n);
    edge_t e;
    e = '{ok: 1'b1, y: '0};
    case (int'(p) * 8 + int'(n))
      0:  e.y = 3'b000;
      1:  e.y = 3'b001;
      8:  e.y = 3'b100;
      9:  e.y = 3'b010;
      10: e.y = 3'b011;
      18: e.y = 3'b000;
      19: e.y = 3'b101;
      27: e.y = 3'b110;
      28: e.y = 3'b001;
      32: e.y = 3'b100;
      33: e.y = 3'b101;
      36: e.y = 3'b010;
      default: e.ok = 1'b0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/sfg_code_decode.sv
module sfg_code_decode
  import sfg_pkg::*;
#(
  parameter enc_e ENC = ENC_ONEHOT,
  parameter int   SW  = NUM_ST
) (
  input  logic [SW-1:0] code,
  output idx_t          idx,
  output logic          valid
);

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      always_comb begin
        idx = '0;
        for (int i = NUM_ST - 1; i >= 0; i--) begin
          if (code[i]) idx = idx_t'(i);
        end
      end
      assign valid = ($countones(code) == 1);
    end else begin : g_binary
      assign idx   = code[IDX_W-1:0];
      assign valid = (int'(code) < NUM_ST);
    end
  endgenerate

endmodule

// File: rtl/sfg_step_logic.sv
module sfg_step_logic
  import sfg_pkg::*;
(
  input  idx_t cur,
  input  in_t  x,
  output idx_t nxt,
  output out_t y
);

  // Undefined inputs keep the state and give the self-loop output.
  always_comb begin
    nxt = cur;
    y   = '0;
    case (int'(cur))
      0: begin
        y = 3'b000;
        if (int'(x) == 1) begin nxt = idx_t'(1); y = 3'b001; end
      end
      1: begin
        y = 3'b010;
        if (int'(x) == 1) begin nxt = idx_t'(2); y = 3'b011; end
        if (int'(x) == 2) begin nxt = idx_t'(0); y = 3'b100; end
      end
      2: begin
        y = 3'b000;
        if (int'(x) == 2) begin nxt = idx_t'(3); y = 3'b101; end
      end
      3: begin
        y = 3'b110;
        if (int'(x) == 1) begin nxt = idx_t'(4); y = 3'b001; end
      end
      4: begin
        y = 3'b010;
        if (int'(x) == 1) begin nxt = idx_t'(0); y = 3'b100; end
        if (int'(x) == 2) begin nxt = idx_t'(1); y = 3'b101; end
      end
      default: begin
        nxt = '0;
        y   = '0;
      end
    endcase
  end

endmodule

// File: rtl/sfg_fault_mon.sv
module sfg_fault_mon
  import sfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  in_t    x,
  input  idx_t   p_idx,
  input  logic   p_ok,
  input  idx_t   n_idx,
  input  logic   n_ok,
  input  out_t   y,
  output cause_t cause_now,
  output cause_t cause_q
);

  edge_t e;

  always_comb begin
    e = edge_lookup(p_idx, n_idx);
    cause_now        = '0;
    cause_now[C_IN]  = !in_global_ok(x) || (p_ok && !in_state_ok(p_idx, x));
    cause_now[C_OUT] = !out_global_ok(y)
                     || (p_ok && !out_state_ok(p_idx, y))
                     || (p_ok && n_ok && e.ok && (y != e.y));
    cause_now[C_PS]  = !p_ok;
    cause_now[C_NS]  = !n_ok;
    cause_now[C_TR]  = p_ok && n_ok && !e.ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_q | cause_now;
  end

  // R9: once set, a cause bit never clears before reset
  p_cause_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

endmodule

// File: rtl/sfg_guarded_fsm.sv
module sfg_guarded_fsm
  import sfg_pkg::*;
#(
  parameter enc_e ENC = ENC_ONEHOT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IN_W-1:0]    x_i,
  input  logic [1:0]         inj_sel_i,
  input  logic [INJ_W-1:0]   inj_mask_i,
  output logic [OUT_W-1:0]   y_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int SW = (ENC == ENC_ONEHOT) ? NUM_ST : IDX_W;
  typedef logic [SW-1:0] code_t;
  localparam code_t RST_CODE = (ENC == ENC_ONEHOT) ? code_t'(1) : code_t'(0);

  code_t  state_q, ps_fb, ns_code, ns_fb, mask_st;
  out_t   y_raw, y_chk, mask_out;
  idx_t   p_idx, n_idx, nxt_idx;
  logic   p_ok, n_ok;
  cause_t cause_now, cause_q;
  inj_e   sel;

  assign sel      = inj_e'(inj_sel_i);
  assign mask_st  = inj_mask_i[SW-1:0];
  assign mask_out = inj_mask_i[OUT_W-1:0];

  // Present state as seen by the logic (feedback path)
  assign ps_fb = state_q ^ ((sel == INJ_STATE) ? mask_st : '0);

  sfg_code_decode #(.ENC(ENC), .SW(SW)) u_dec_ps (
    .code(ps_fb), .idx(p_idx), .valid(p_ok)
  );

  sfg_step_logic u_step (
    .cur(p_idx), .x(x_i), .nxt(nxt_idx), .y(y_raw)
  );

  generate
    if (ENC == ENC_ONEHOT) begin : g_enc_oh
      assign ns_code = code_t'(1) << nxt_idx;
    end else begin : g_enc_bin
      assign ns_code = nxt_idx;
    end
  endgenerate

  assign ns_fb = ns_code ^ ((sel == INJ_NEXT) ? mask_st : '0);
  assign y_chk = y_raw ^ ((sel == INJ_OUT) ? mask_out : '0);

  sfg_code_decode #(.ENC(ENC), .SW(SW)) u_dec_ns (
    .code(ns_fb), .idx(n_idx), .valid(n_ok)
  );

  sfg_fault_mon u_mon (
    .clk(clk), .rst_n(rst_n), .x(x_i),
    .p_idx(p_idx), .p_ok(p_ok), .n_idx(n_idx), .n_ok(n_ok),
    .y(y_chk), .cause_now(cause_now), .cause_q(cause_q)
  );

  assign cause_o = cause_q | cause_now;
  assign fault_o = |cause_o;
  assign y_o     = fault_o ? '0 : y_chk;

  always_ff @(posedge clk) begin
    if (!rst_n)        state_q <= RST_CODE;
    else if (!fault_o) state_q <= ns_fb;
  end

  // R8: outputs remain safe in every cycle after a fault
  p_mask_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> (y_o == '0));

  // R9: fault flag is sticky
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  // R6: no state load while faulted
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> $stable(state_q));

  // R10: a clean cycle only ever loads a valid code
  p_clean_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |=> (p_ok || (sel == INJ_STATE)));

  // R5: an invalid present code never reaches the controlled object
  p_bad_state_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !p_ok |-> (y_o == '0));

endmodule

// File: tb/tb_sfg_guarded_fsm.sv
module tb_sfg_guarded_fsm;
  import sfg_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] x = 2'b00;
  logic [1:0] sel_a = 2'b00, sel_b = 2'b00;
  logic [4:0] mask_a = 5'b0, mask_b = 5'b0;
  logic [2:0] y_a, y_b;
  logic       f_a, f_b;
  logic [4:0] c_a, c_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int         nx_t [5][4];
  logic [2:0] oy_t [5][4];
  bit         df_t [5][4];
  logic [1:0] path [4];

  sfg_guarded_fsm #(.ENC(ENC_ONEHOT)) dut (
    .clk(clk), .rst_n(rst_n), .x_i(x), .inj_sel_i(sel_a), .inj_mask_i(mask_a),
    .y_o(y_a), .fault_o(f_a), .cause_o(c_a));

  sfg_guarded_fsm #(.ENC(ENC_BINARY)) dut_b (
    .clk(clk), .rst_n(rst_n), .x_i(x), .inj_sel_i(sel_b), .inj_mask_i(mask_b),
    .y_o(y_b), .fault_o(f_b), .cause_o(c_b));

  task automatic chk(string tag, logic [2:0] y, logic f, logic [4:0] c,
                     logic [2:0] ey, logic ef, logic [4:0] ec);
    n_cmp++;
    if (y !== ey || f !== ef || c !== ec) begin
      n_bad++;
      $display("FAIL %s: y=%b fault=%b cause=%b expected y=%b fault=%b cause=%b",
               tag, y, f, c, ey, ef, ec);
    end
  endtask

  task automatic drive(logic [1:0] xv);
    @(negedge clk);
    x = xv;
    #1;
  endtask

  // R1: reset state, checked on both encodings
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; x = 2'b00;
    sel_a = 2'b00; sel_b = 2'b00; mask_a = 5'b0; mask_b = 5'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset onehot", y_a, f_a, c_a, 3'b000, 1'b0, 5'b00000);
    chk("R1 reset binary", y_b, f_b, c_b, 3'b000, 1'b0, 5'b00000);
  endtask

  task automatic inj_case(string tag, bit to_b, int steps, logic [1:0] xv,
                          logic [1:0] sel, logic [4:0] mask, logic [4:0] ec);
    int cur;
    logic [2:0] oy;
    logic of;
    logic [4:0] oc;
    do_reset();
    cur = 0;
    for (int k = 0; k < steps; k++) begin
      drive(path[k]);
      cur = nx_t[cur][path[k]];
    end
    if (df_t[cur][xv]) begin oy = oy_t[cur][xv]; of = 1'b0; oc = 5'b00000; end
    else               begin oy = 3'b000;        of = 1'b1; oc = 5'b00001; end
    @(negedge clk);
    x = xv;
    if (to_b) begin sel_b = sel; mask_b = mask; end
    else      begin sel_a = sel; mask_a = mask; end
    #1;
    if (to_b) begin
      chk({tag, " binary R8"}, y_b, f_b, c_b, 3'b000, 1'b1, ec);
      chk({tag, " onehot untouched R11"}, y_a, f_a, c_a, oy, of, oc);
    end else begin
      chk({tag, " onehot R8"}, y_a, f_a, c_a, 3'b000, 1'b1, ec);
      chk({tag, " binary untouched R11"}, y_b, f_b, c_b, oy, of, oc);
    end
    @(negedge clk);
    x = 2'b00; sel_a = 2'b00; sel_b = 2'b00; mask_a = 5'b0; mask_b = 5'b0;
    #1;
    if (to_b) chk({tag, " sticky R9"}, y_b, f_b, c_b, 3'b000, 1'b1, ec);
    else      chk({tag, " sticky R9"}, y_a, f_a, c_a, 3'b000, 1'b1, ec);
  endtask

  initial begin
    nx_t = '{'{0,1,0,0}, '{1,2,0,1}, '{2,2,3,2}, '{3,4,3,3}, '{4,0,1,4}};
    oy_t = '{'{3'd0,3'd1,3'd0,3'd0}, '{3'd2,3'd3,3'd4,3'd2}, '{3'd0,3'd0,3'd5,3'd0},
             '{3'd6,3'd1,3'd6,3'd6}, '{3'd2,3'd4,3'd5,3'd2}};
    df_t = '{'{1,1,0,0}, '{1,1,1,0}, '{1,0,1,0}, '{1,1,0,0}, '{1,1,1,0}};
    path = '{2'b01, 2'b01, 2'b10, 2'b01};

    // R2, R3, R10: every state/input pair from reset on both encodings
    for (int s = 0; s < 5; s++) begin
      for (int xi = 0; xi < 4; xi++) begin
        int cur;
        do_reset();
        cur = 0;
        for (int k = 0; k < s; k++) begin
          drive(path[k]);
          chk("R2 walk onehot", y_a, f_a, c_a, oy_t[cur][path[k]], 1'b0, 5'b00000);
          chk("R10 walk binary", y_b, f_b, c_b, oy_t[cur][path[k]], 1'b0, 5'b00000);
          cur = nx_t[cur][path[k]];
        end
        drive(2'(xi));
        if (df_t[cur][xi]) begin
          chk("R2 step onehot", y_a, f_a, c_a, oy_t[cur][xi], 1'b0, 5'b00000);
          chk("R10 step binary", y_b, f_b, c_b, oy_t[cur][xi], 1'b0, 5'b00000);
          cur = nx_t[cur][xi];
          drive(2'b00);
          chk("R2 next onehot", y_a, f_a, c_a, oy_t[cur][0], 1'b0, 5'b00000);
          chk("R10 next binary", y_b, f_b, c_b, oy_t[cur][0], 1'b0, 5'b00000);
        end else begin
          chk("R3 illegal input onehot", y_a, f_a, c_a, 3'b000, 1'b1, 5'b00001);
          chk("R3 illegal input binary", y_b, f_b, c_b, 3'b000, 1'b1, 5'b00001);
          drive(2'b00);
          chk("R9 input sticky onehot", y_a, f_a, c_a, 3'b000, 1'b1, 5'b00001);
          chk("R9 input sticky binary", y_b, f_b, c_b, 3'b000, 1'b1, 5'b00001);
        end
      end
    end

    // Injection cases on the one-hot instance
    inj_case("R5 present flip",       1'b0, 0, 2'b00, 2'b01, 5'b00010, 5'b00100);
    inj_case("R6 next invalid",       1'b0, 1, 2'b00, 2'b10, 5'b00001, 5'b01000);
    inj_case("R7 transition",         1'b0, 0, 2'b00, 2'b10, 5'b00101, 5'b10000);
    inj_case("R4 output edge",        1'b0, 0, 2'b01, 2'b11, 5'b00001, 5'b00010);
    inj_case("R4 output global",      1'b0, 3, 2'b00, 2'b11, 5'b00001, 5'b00010);
    inj_case("R12 input plus output", 1'b0, 1, 2'b11, 2'b11, 5'b00001, 5'b00011);
    // Injection cases on the binary instance
    inj_case("R5 R10 present flip",   1'b1, 0, 2'b00, 2'b01, 5'b00101, 5'b00100);
    inj_case("R6 R10 next invalid",   1'b1, 0, 2'b00, 2'b10, 5'b00101, 5'b01000);
    inj_case("R7 R10 transition",     1'b1, 0, 2'b00, 2'b10, 5'b00010, 5'b10000);
    inj_case("R4 R10 output edge",    1'b1, 4, 2'b01, 2'b11, 5'b00010, 5'b00010);

    // R9: reset is the way out of a fault
    do_reset();
    drive(2'b01);
    chk("R9 after reset onehot", y_a, f_a, c_a, 3'b001, 1'b0, 5'b00000);
    chk("R9 after reset binary", y_b, f_b, c_b, 3'b001, 1'b0, 5'b00000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule